// File: doc/BRIEF.md
# Register-to-NAND Flash Bus Bridge

This block lets a host drive a raw 8-bit NAND flash device through one packed 32-bit register. A host write to the data register holds three things: a chip-enable bit, a 3-bit operation code and one data byte. Depending on the code, the bridge runs one timed strobe cycle on the NAND pins: a command-latch cycle, an address-latch cycle or a plain data write. It can also arm read mode, which runs no strobe.

While read mode is armed, every host read of the data register fires one read strobe on the NAND. The byte captured on the rising edge of that strobe comes back in the read word. A second register address returns the device's ready/busy state. Each host request is accepted only while `host_ready` is high. It is completed by a one-cycle `host_ack`, and `host_rdata` is valid in that cycle. The widths of the setup, pulse and hold phases are parameters.

Top module: `nand_reg_bridge`

## Requirements
- R1: After reset, `nand_ce_n`, `nand_we_n` and `nand_re_n` are high, `nand_cle` and `nand_ale` are low, `host_ready` is high and read mode is disarmed.
- R2: A data-register write (`host_sel`=0, `host_we`=1) takes its operation code from bits 30:28. Code 0 runs a command cycle: `nand_cle`=1 and `nand_ale`=0 while `nand_we_n` is low, and bits 23:16 of the write word appear on `nand_dq`.
- R3: Code 1 runs an address cycle: `nand_ale`=1 and `nand_cle`=0 while `nand_we_n` is low, and bits 23:16 appear on `nand_dq`.
- R4: Code 3 runs a data write cycle: `nand_cle`=0 and `nand_ale`=0 while `nand_we_n` is low, and bits 23:16 appear on `nand_dq`.
- R5: Bit 31 of a data-register write sets the chip enable. `nand_ce_n` is low exactly when the last such write had bit 31 set, and it stays unchanged during strobe cycles.
- R6: A strobe cycle has SETUP_CYC cycles with the strobe high, then exactly PULSE_CYC cycles with the strobe low, then HOLD_CYC cycles. `host_ack` rises SETUP_CYC+PULSE_CYC+HOLD_CYC+1 clock edges after the accepting edge. `host_ready` stays low until then, and `host_ack` lasts one cycle.
- R7: Code 2 arms read mode. It produces no `nand_we_n` pulse and is acknowledged one edge after acceptance.
- R8: An armed data-register read (`host_sel`=0, `host_we`=0) produces exactly one `nand_re_n` low pulse of PULSE_CYC cycles. The byte on `nand_dq` at the rising edge of `nand_re_n` is returned in `host_rdata[23:16]`, and all other bits are zero.
- R9: Read mode stays armed across any number of data-register reads. A data-register read while disarmed produces no `nand_re_n` pulse, returns zero and is acknowledged one edge after acceptance.
- R10: A status read (`host_sel`=1, `host_we`=0) returns bit 15 = 1 when `nand_rb_n` is low (busy) and 0 when it is high. All other bits are zero. It makes no NAND strobe and is acknowledged one edge after acceptance.
- R11: Codes 4 to 7 make no NAND strobe, disarm read mode, drive `nand_cle` and `nand_ale` low, and are acknowledged one edge after acceptance.
- R12: `nand_we_n` and `nand_re_n` are never low together. The bridge drives `nand_dq` only during write strobe cycles and never while `nand_re_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host request, taken when host_ready is high |
| host_we | input | 1 | 1 = write, 0 = read |
| host_sel | input | 1 | 0 = data register, 1 = status register |
| host_wdata | input | 32 | Write word: bit 31 chip enable, 30:28 operation, 23:16 byte |
| host_ready | output | 1 | Bridge idle and able to accept a request |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read word, valid with host_ack |
| nand_ce_n | output | 1 | NAND chip enable, active low |
| nand_cle | output | 1 | NAND command latch enable |
| nand_ale | output | 1 | NAND address latch enable |
| nand_we_n | output | 1 | NAND write strobe, active low |
| nand_re_n | output | 1 | NAND read strobe, active low |
| nand_rb_n | input | 1 | NAND ready/busy, low = busy |
| nand_dq | inout | 8 | NAND data bus |

## Verification
A wrong phase counter shows on the strobe pins within one transaction. The low pulse gets longer or shorter, its first low cycle moves away from SETUP_CYC+1, or the acknowledge latency changes. A stale operation decode or a stale read-mode flag shows on the very next request. Either the latch lines are wrong while `nand_we_n` is low, or a read after arming yields no `nand_re_n` pulse (or a read after disarming yields one). A wrong capture point shows as the wrong byte in `host_rdata[23:16]` on that same read's acknowledge.

// File: rtl/nand_bridge_pkg.sv
package nand_bridge_pkg;
    localparam int WORD_W   = 32;
    localparam int BYTE_W   = 8;
    localparam int CE_POS   = 31;
    localparam int OP_HI    = 30;
    localparam int OP_LO    = 28;
    localparam int BYTE_LO  = 16;
    localparam int BUSY_POS = 15;

    localparam logic [2:0] OPC_CMD  = 3'd0;
    localparam logic [2:0] OPC_ADDR = 3'd1;
    localparam logic [2:0] OPC_ARM  = 3'd2;
    localparam logic [2:0] OPC_DATA = 3'd3;

    typedef enum logic [2:0] {K_CMD, K_ADDR, K_DATA, K_ARM, K_NONE} op_kind_e;
    typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_PULSE, PH_HOLD} phase_e;
    typedef enum logic [1:0] {ST_IDLE, ST_STROBE, ST_DONE} host_st_e;
endpackage

// File: rtl/nand_op_decode.sv
module nand_op_decode
    import nand_bridge_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output op_kind_e          kind,
    output logic              ce,
    output logic              cle,
    output logic              ale,
    output logic              strobe,
    output logic [BYTE_W-1:0] wbyte
);
    always_comb begin
        ce     = word[CE_POS];
        wbyte  = word[BYTE_LO +: BYTE_W];
        cle    = 1'b0;
        ale    = 1'b0;
        strobe = 1'b0;
        unique case (word[OP_HI:OP_LO])
            OPC_CMD:  begin kind = K_CMD;  cle = 1'b1; strobe = 1'b1; end
            OPC_ADDR: begin kind = K_ADDR; ale = 1'b1; strobe = 1'b1; end
            OPC_DATA: begin kind = K_DATA; strobe = 1'b1; end
            OPC_ARM:  kind = K_ARM;
            default:  kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/nand_phase_timer.sv
module nand_phase_timer
    import nand_bridge_pkg::*;
#(
    parameter int SETUP_CYC = 2,
    parameter int PULSE_CYC = 3,
    parameter int HOLD_CYC  = 1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    output phase_e phase,
    output logic   pulse_end,
    output logic   fin
);
    localparam int MAX_A = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
    localparam int MAX_C = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
    localparam int CNT_W = $clog2(MAX_C + 1);
    localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(HOLD_CYC - 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t d, q;

    always_comb begin
        d = q;
        if (q.phase == PH_IDLE) begin
            if (start) begin
                d.phase = PH_SETUP;
                d.cnt   = LD_SETUP;
            end
        end else if (q.cnt != '0) begin
            d.cnt = q.cnt - 1'b1;
        end else begin
            unique case (q.phase)
                PH_SETUP: begin d.phase = PH_PULSE; d.cnt = LD_PULSE; end
                PH_PULSE: begin d.phase = PH_HOLD;  d.cnt = LD_HOLD;  end
                default:  begin d.phase = PH_IDLE;  d.cnt = '0;       end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.phase <= PH_IDLE;
            q.cnt   <= '0;
        end else begin
            q <= d;
        end
    end

    assign phase     = q.phase;
    assign pulse_end = (q.phase == PH_PULSE) && (q.cnt == '0);
    assign fin       = (q.phase == PH_HOLD) && (q.cnt == '0);

    // R6: the low pulse is entered only from setup and left only into hold
    p_pulse_after_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_PULSE) |-> ($past(q.phase) == PH_SETUP || $past(q.phase) == PH_PULSE));
    p_hold_after_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_HOLD) |-> ($past(q.phase) == PH_PULSE || $past(q.phase) == PH_HOLD));
    p_start_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (q.phase == PH_IDLE));
endmodule

// File: rtl/nand_reg_bridge.sv
module nand_reg_bridge
    import nand_bridge_pkg::*;
#(
    parameter int SETUP_CYC = 2,
    parameter int PULSE_CYC = 3,
    parameter int HOLD_CYC  = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_valid,
    input  logic        host_we,
    input  logic        host_sel,
    input  logic [31:0] host_wdata,
    output logic        host_ready,
    output logic        host_ack,
    output logic [31:0] host_rdata,
    output logic        nand_ce_n,
    output logic        nand_cle,
    output logic        nand_ale,
    output logic        nand_we_n,
    output logic        nand_re_n,
    input  logic        nand_rb_n,
    inout  wire  [7:0]  nand_dq
);
    typedef struct packed {
        host_st_e          st;
        logic              rd;
        logic              ce;
        logic              cle;
        logic              ale;
        logic              armed;
        logic [BYTE_W-1:0] wbyte;
        logic [WORD_W-1:0] rdata;
        logic              rb_s1;
        logic              rb_s2;
    } ctl_t;

    ctl_t d, q;

    op_kind_e          dec_kind;
    logic              dec_ce, dec_cle, dec_ale, dec_strobe;
    logic [BYTE_W-1:0] dec_byte;
    logic              tmr_start, t_pulse_end, t_fin;
    phase_e            t_phase;
    logic              drive_dq;

    nand_op_decode u_dec (
        .word   (host_wdata),
        .kind   (dec_kind),
        .ce     (dec_ce),
        .cle    (dec_cle),
        .ale    (dec_ale),
        .strobe (dec_strobe),
        .wbyte  (dec_byte)
    );

    nand_phase_timer #(
        .SETUP_CYC (SETUP_CYC),
        .PULSE_CYC (PULSE_CYC),
        .HOLD_CYC  (HOLD_CYC)
    ) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (tmr_start),
        .phase     (t_phase),
        .pulse_end (t_pulse_end),
        .fin       (t_fin)
    );

    always_comb begin
        d         = q;
        tmr_start = 1'b0;
        d.rb_s1   = nand_rb_n;
        d.rb_s2   = q.rb_s1;
        unique case (q.st)
            ST_IDLE: begin
                if (host_valid) begin
                    if (host_sel) begin
                        d.rdata = '0;
                        if (!host_we) d.rdata[BUSY_POS] = ~q.rb_s2;
                        d.st = ST_DONE;
                    end else if (host_we) begin
                        d.ce    = dec_ce;
                        d.cle   = dec_cle;
                        d.ale   = dec_ale;
                        d.armed = (dec_kind == K_ARM);
                        d.wbyte = dec_byte;
                        d.rd    = 1'b0;
                        d.rdata = '0;
                        if (dec_strobe) begin
                            tmr_start = 1'b1;
                            d.st      = ST_STROBE;
                        end else begin
                            d.st = ST_DONE;
                        end
                    end else if (q.armed) begin
                        d.rd      = 1'b1;
                        d.rdata   = '0;
                        tmr_start = 1'b1;
                        d.st      = ST_STROBE;
                    end else begin
                        d.rdata = '0;
                        d.st    = ST_DONE;
                    end
                end
            end
            ST_STROBE: begin
                if (q.rd && t_pulse_end) d.rdata[BYTE_LO +: BYTE_W] = nand_dq;
                if (t_fin) d.st = ST_DONE;
            end
            ST_DONE: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.rd    <= 1'b0;
            q.ce    <= 1'b0;
            q.cle   <= 1'b0;
            q.ale   <= 1'b0;
            q.armed <= 1'b0;
            q.wbyte <= '0;
            q.rdata <= '0;
            q.rb_s1 <= 1'b1;
            q.rb_s2 <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign drive_dq   = (q.st == ST_STROBE) && !q.rd;
    assign nand_dq    = drive_dq ? q.wbyte : {BYTE_W{1'bz}};
    assign nand_we_n  = !(drive_dq && t_phase == PH_PULSE);
    assign nand_re_n  = !((q.st == ST_STROBE) && q.rd && t_phase == PH_PULSE);
    assign nand_ce_n  = !q.ce;
    assign nand_cle   = q.cle;
    assign nand_ale   = q.ale;
    assign host_ready = (q.st == ST_IDLE);
    assign host_ack   = (q.st == ST_DONE);
    assign host_rdata = q.rdata;

    // R12: strobes exclusive; bus driver off while the device may drive
    p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));
    p_drive_not_reading_r12: assert property (@(posedge clk) disable iff (!rst_n)
        drive_dq |-> nand_re_n);
    // R2: latch lines never both high during a write strobe
    p_latch_lines_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> !(nand_cle && nand_ale));
    // R3: latch lines steady across a write pulse
    p_latch_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n && $past(!nand_we_n)) |-> ($stable(nand_cle) && $stable(nand_ale)));
    // R5: chip enable steady once a strobe cycle is under way
    p_ce_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_STROBE && $past(q.st == ST_STROBE)) |-> $stable(nand_ce_n));
    // R6: acknowledge is a single-cycle pulse
    p_ack_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);
    // R7: arming completes on the next edge without a write strobe
    p_arm_fast_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ready && host_valid && host_we && !host_sel && dec_kind == K_ARM)
        |=> (host_ack && nand_we_n));
    // R8: read word carries only the byte field
    p_rdata_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ack && !$past(host_sel)) |-> (host_rdata[31:24] == '0 && host_rdata[15:0] == '0));
    // R9: no read strobe unless read mode is armed
    p_re_needs_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> q.armed);
    // R10: status read answers on the next edge with only the busy bit
    p_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ready && host_valid && !host_we && host_sel)
        |=> (host_ack && host_rdata[31:16] == '0 && host_rdata[14:0] == '0));
    // R11: unassigned codes disarm read mode
    p_other_disarm_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ready && host_valid && host_we && !host_sel && dec_kind == K_NONE)
        |=> (!q.armed && host_ack));
endmodule

// File: tb/sim_nand_reg_bridge.sv
module sim_nand_reg_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int S = 2;
    localparam int P = 3;
    localparam int H = 1;
    localparam int LAT_STROBE = S + P + H + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0;
    logic        host_we = 1'b0;
    logic        host_sel = 1'b0;
    logic [31:0] host_wdata = '0;
    logic        host_ready, host_ack;
    logic [31:0] host_rdata;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n;
    logic        nand_rb_n = 1'b1;
    wire  [7:0]  nand_dq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // NAND data model: returns a byte depending on how many read strobes it has seen
    bit          model_on = 0;
    int unsigned strobes = 0;
    logic [7:0]  mdl_byte;

    function automatic logic [7:0] fbyte(input int unsigned k);
        return 8'h5A ^ 8'(k * 37);
    endfunction

    assign mdl_byte = fbyte(strobes);
    assign nand_dq  = !nand_re_n ? mdl_byte : 8'bz;

    always @(posedge nand_re_n) if (model_on) strobes <= strobes + 1;

    int overlap = 0;
    always @(negedge clk) if (rst_n && !nand_we_n && !nand_re_n) overlap++;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nand_reg_bridge #(.SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H)) u0 (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_we(host_we),
        .host_sel(host_sel), .host_wdata(host_wdata), .host_ready(host_ready),
        .host_ack(host_ack), .host_rdata(host_rdata), .nand_ce_n(nand_ce_n),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_rb_n(nand_rb_n), .nand_dq(nand_dq)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // observations from the last transaction
    int         lat, we_lo, re_lo, first_lo, rdy_bad;
    logic       cle_s, ale_s, ce_n_s;
    logic [7:0] dq_s;
    logic [31:0] rdata_s;

    task automatic xact(input logic sel, input logic we, input logic [31:0] wd);
        lat = 0; we_lo = 0; re_lo = 0; first_lo = 0; rdy_bad = 0;
        @(negedge clk);
        host_valid = 1'b1; host_sel = sel; host_we = we; host_wdata = wd;
        @(negedge clk);
        host_valid = 1'b0;
        while (1) begin
            lat++;
            if (!nand_we_n) begin
                we_lo++;
                if (first_lo == 0) first_lo = lat;
                cle_s = nand_cle; ale_s = nand_ale; dq_s = nand_dq; ce_n_s = nand_ce_n;
            end
            if (!nand_re_n) re_lo++;
            if (host_ack) begin
                rdata_s = host_rdata;
                break;
            end
            if (host_ready) rdy_bad++;
            if (lat > 100) break;
            @(negedge clk);
        end
    endtask

    initial begin
        int unsigned exp_k;
        exp_k = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        model_on = 1;
        // R1 reset state
        chk(nand_ce_n == 1'b1, "R1 ce_n", nand_ce_n, 1);
        chk(nand_we_n == 1'b1 && nand_re_n == 1'b1, "R1 strobes", {nand_we_n, nand_re_n}, 3);
        chk(nand_cle == 1'b0 && nand_ale == 1'b0, "R1 latch lines", {nand_cle, nand_ale}, 0);
        chk(host_ready == 1'b1, "R1 ready", host_ready, 1);
        // R1/R9 disarmed read after reset
        xact(1'b0, 1'b0, 32'h0);
        chk(re_lo == 0, "R1 no read strobe", re_lo, 0);
        chk(rdata_s == 32'h0, "R9 disarmed data", rdata_s, 0);
        chk(lat == 1, "R9 disarmed latency", lat, 1);

        // sweep over every operation code, chip enable value and many bytes
        for (int op = 0; op < 8; op++) begin
            for (int ce = 0; ce < 2; ce++) begin
                for (int b = 0; b < 256; b += ((op == 0 || op == 1 || op == 3) ? 1 : 85)) begin
                    logic [31:0] w;
                    bit strobe_op;
                    w = {ce[0], op[2:0], 4'h0, b[7:0], 16'h0};
                    strobe_op = (op == 0 || op == 1 || op == 3);
                    xact(1'b0, 1'b1, w);
                    if (strobe_op) begin
                        chk(lat == LAT_STROBE, "R6 write latency", lat, LAT_STROBE);
                        chk(we_lo == P, "R6 we pulse width", we_lo, P);
                        chk(first_lo == S + 1, "R6 setup length", first_lo, S + 1);
                        chk(rdy_bad == 0, "R6 ready low while busy", rdy_bad, 0);
                        chk(dq_s == b[7:0], op == 0 ? "R2 dq" : (op == 1 ? "R3 dq" : "R4 dq"), dq_s, b);
                        chk(cle_s == (op == 0), op == 0 ? "R2 cle" : "R4 cle", cle_s, op == 0);
                        chk(ale_s == (op == 1), op == 1 ? "R3 ale" : "R4 ale", ale_s, op == 1);
                        chk(ce_n_s == !ce[0], "R5 ce during strobe", ce_n_s, !ce[0]);
                    end else begin
                        chk(we_lo == 0, op == 2 ? "R7 no we pulse" : "R11 no we pulse", we_lo, 0);
                        chk(lat == 1, op == 2 ? "R7 latency" : "R11 latency", lat, 1);
                    end
                    @(negedge clk);
                    chk(nand_ce_n == !ce[0], "R5 ce after write", nand_ce_n, !ce[0]);
                    if (op >= 4)
                        chk(nand_cle == 1'b0 && nand_ale == 1'b0, "R11 latch lines low",
                            {nand_cle, nand_ale}, 0);
                    // follow-up read shows whether read mode is armed
                    xact(1'b0, 1'b0, 32'h0);
                    if (op == 2) begin
                        chk(re_lo == P, "R8 re pulse width", re_lo, P);
                        chk(lat == LAT_STROBE, "R8 read latency", lat, LAT_STROBE);
                        chk(rdata_s == {8'h0, fbyte(exp_k), 16'h0}, "R8 read data",
                            rdata_s, {8'h0, fbyte(exp_k), 16'h0});
                        exp_k++;
                    end else begin
                        chk(re_lo == 0, op >= 4 ? "R11 disarmed read" : "R9 disarmed read", re_lo, 0);
                        chk(rdata_s == 32'h0, "R9 disarmed data", rdata_s, 0);
                    end
                end
            end
        end

        // R9 burst of reads while armed
        xact(1'b0, 1'b1, {1'b1, 3'd2, 28'h0});
        for (int i = 0; i < 40; i++) begin
            xact(1'b0, 1'b0, 32'h0);
            chk(re_lo == P, "R9 armed burst strobe", re_lo, P);
            chk(rdata_s == {8'h0, fbyte(exp_k), 16'h0}, "R8 burst data",
                rdata_s, {8'h0, fbyte(exp_k), 16'h0});
            exp_k++;
        end

        // R10 status reads with ready/busy both ways, read mode still armed
        for (int i = 0; i < 6; i++) begin
            nand_rb_n = i[0];
            repeat (4) @(negedge clk);
            xact(1'b1, 1'b0, 32'h0);
            chk(rdata_s == (i[0] ? 32'h0 : 32'h0000_8000), "R10 status word",
                rdata_s, i[0] ? 32'h0 : 32'h8000);
            chk(re_lo == 0 && we_lo == 0, "R10 no strobe", re_lo + we_lo, 0);
            chk(lat == 1, "R10 latency", lat, 1);
        end
        nand_rb_n = 1'b1;

        chk(strobes == exp_k, "R8 strobe count", strobes, exp_k);
        chk(overlap == 0, "R12 strobe overlap", overlap, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule